// File: doc/BRIEF.md
# Privileged Tag-Seed System Register

This block is one 64-bit system register that holds the seed and the most recent result of an allocation-tag generator, together with the logic that decides whether a given access is allowed. Each cycle a request may arrive carrying the five encoding fields of a system-register instruction, a direction and write data. The block compares the encoding against its own address. It then works out, from the current exception level and a handful of configuration inputs, whether the access proceeds, is treated as an undefined instruction, or is trapped to the level-2 hypervisor or to the level-3 monitor.

The answer comes back in the same cycle as a one-hot outcome vector, along with read data and a trap syndrome class. An allowed write is masked to the fields that the current layout defines. A mode input chooses between a narrow layout (16-bit seed) and a wide layout (48-bit seed). A separate update port lets the tag generator load a new tag and seed. If that update arrives in the same cycle as a permitted software write, the software write wins.

Top module: `tag_seed_sysreg`

## Requirements
- R1: The register answers only when a request is valid and its encoding is op0=2'b11, op1=3'b000, CRn=4'b0001, CRm=4'b0000, op2=3'b101. For any other encoding the outcome is 4'b0000 and the stored value does not change.
- R2: A hit from exception level 0 (curEl=2'd0) gives outcome undef.
- R3: A hit from level 1 applies these checks in order: (a) if the level-3 monitor is present, sddUndefPrio=1 and monTagAccess=0, the outcome is undef; (b) otherwise, if el2Enabled=1 and hypTagAccess=0, the outcome is trapEl2; (c) otherwise, if the monitor is present and monTagAccess=0, the outcome is undef when sddUndef=1 and trapEl3 when sddUndef=0; (d) otherwise the outcome is ok.
- R4: A hit from level 2 applies the level-1 chain with step (b) removed, so it never gives trapEl2.
- R5: A hit from level 3 always gives outcome ok.
- R6: syndromeClass is 6'h18 whenever the outcome is trapEl2 or trapEl3, and 0 otherwise.
- R7: When wideSeedMode=0, a permitted write keeps only bits [23:8] (seed) and [3:0] (tag). A read returns zero in bits [63:24] and [7:4].
- R8: When wideSeedMode=1, a permitted write keeps bits [55:8] and [3:0]. A read returns zero in bits [63:56] and [7:4].
- R9: A permitted write is returned by a read in the very next cycle.
- R10: After reset the stored value is zero.
- R11: When genValid=1, the register loads genTag into [3:0] and genSeed, starting at bit 8, into the seed field, masked by the current layout. A permitted software write in the same cycle overrides this load.
- R12: Outcome is one-hot on every hit, with bit order {trapEl3, trapEl2, undef, ok} (ok = bit 0). rdata is nonzero only for a permitted read. A write whose outcome is not ok leaves the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqOp0 | input | 2 | Encoding field op0 |
| reqOp1 | input | 3 | Encoding field op1 |
| reqCrn | input | 4 | Encoding field CRn |
| reqCrm | input | 4 | Encoding field CRm |
| reqOp2 | input | 3 | Encoding field op2 |
| reqWdata | input | 64 | Write data |
| curEl | input | 2 | Current exception level |
| el3Present | input | 1 | Level-3 monitor is implemented |
| el2Enabled | input | 1 | Level-2 hypervisor is enabled for this access |
| sddUndefPrio | input | 1 | Secure-debug-disable: undefined takes priority |
| sddUndef | input | 1 | Secure-debug-disable: monitor trap becomes undefined |
| hypTagAccess | input | 1 | Hypervisor allows tag register access |
| monTagAccess | input | 1 | Monitor allows tag register access |
| wideSeedMode | input | 1 | 1 = 48-bit seed layout, 0 = 16-bit seed layout |
| genValid | input | 1 | Tag generator update strobe |
| genTag | input | 4 | New tag from generator |
| genSeed | input | 48 | New seed from generator |
| outcome | output | 4 | One-hot {trapEl3, trapEl2, undef, ok} |
| rdata | output | 64 | Read data, valid with ok on a read |
| syndromeClass | output | 6 | Trap syndrome class |

## Verification
The assertions assume that the request fields and configuration inputs are stable across each clock edge. They also assume that wideSeedMode changes only between accesses, never in the same cycle as a write, so that the stored image and the read mask describe the same layout. The stimulus drives every input just after the falling edge and holds it through the next rising edge. It changes the mode only while no request or generator update is active, and all checks are sampled in the middle of the low phase.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
  localparam int REG_W         = 64;
  localparam int TAG_W         = 4;
  localparam int SEED_LSB      = 8;
  localparam int NARROW_SEED_W = 16;
  localparam int WIDE_SEED_W   = 48;
  localparam int CLASS_W       = 6;
  localparam logic [CLASS_W-1:0] TRAP_CLASS = 6'h18;

  typedef enum logic [1:0] {LVL0 = 2'd0, LVL1 = 2'd1, LVL2 = 2'd2, LVL3 = 2'd3} excLevel_t;

  typedef struct packed {
    logic trapEl3;
    logic trapEl2;
    logic undef;
    logic ok;
  } outcome_t;

  typedef struct packed {
    logic wrEn;
    logic rdEn;
    logic genEn;
  } tsrStrobes_t;

  function automatic logic [REG_W-1:0] fieldMask(input logic wide);
    logic [REG_W-1:0] m;
    int seedW;
    m = '0;
    seedW = wide ? WIDE_SEED_W : NARROW_SEED_W;
    for (int i = 0; i < REG_W; i++) begin
      if (i < TAG_W || (i >= SEED_LSB && i < SEED_LSB + seedW)) m[i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/tsr_access_ctrl.sv
module tsr_access_ctrl
  import tsr_pkg::*;
#(
  parameter logic [1:0] ENC_OP0 = 2'b11,
  parameter logic [2:0] ENC_OP1 = 3'b000,
  parameter logic [3:0] ENC_CRN = 4'b0001,
  parameter logic [3:0] ENC_CRM = 4'b0000,
  parameter logic [2:0] ENC_OP2 = 3'b101
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic                reqWrite,
  input  logic [1:0]          reqOp0,
  input  logic [2:0]          reqOp1,
  input  logic [3:0]          reqCrn,
  input  logic [3:0]          reqCrm,
  input  logic [2:0]          reqOp2,
  input  logic [1:0]          curEl,
  input  logic                el3Present,
  input  logic                el2Enabled,
  input  logic                sddUndefPrio,
  input  logic                sddUndef,
  input  logic                hypTagAccess,
  input  logic                monTagAccess,
  input  logic                genValid,
  output outcome_t            outcome,
  output logic [CLASS_W-1:0]  syndromeClass,
  output tsrStrobes_t         strobes
);
  logic hit;
  logic monBlocks;
  excLevel_t lvl;

  assign hit = reqValid && reqOp0 == ENC_OP0 && reqOp1 == ENC_OP1 &&
               reqCrn == ENC_CRN && reqCrm == ENC_CRM && reqOp2 == ENC_OP2;
  assign lvl = excLevel_t'(curEl);
  assign monBlocks = el3Present && !monTagAccess;

  always_comb begin
    outcome = '0;
    if (hit) begin
      unique case (lvl)
        LVL0: outcome.undef = 1'b1;
        LVL1: begin
          if (monBlocks && sddUndefPrio)          outcome.undef   = 1'b1;
          else if (el2Enabled && !hypTagAccess)   outcome.trapEl2 = 1'b1;
          else if (monBlocks && sddUndef)         outcome.undef   = 1'b1;
          else if (monBlocks)                     outcome.trapEl3 = 1'b1;
          else                                    outcome.ok      = 1'b1;
        end
        LVL2: begin
          if (monBlocks && sddUndefPrio)          outcome.undef   = 1'b1;
          else if (monBlocks && sddUndef)         outcome.undef   = 1'b1;
          else if (monBlocks)                     outcome.trapEl3 = 1'b1;
          else                                    outcome.ok      = 1'b1;
        end
        LVL3: outcome.ok = 1'b1;
        default: outcome.undef = 1'b1;
      endcase
    end
  end

  assign syndromeClass = (outcome.trapEl2 || outcome.trapEl3) ? TRAP_CLASS : '0;

  always_comb begin
    strobes.wrEn  = outcome.ok && reqWrite;
    strobes.rdEn  = outcome.ok && !reqWrite;
    strobes.genEn = genValid && !strobes.wrEn;
  end

  AST_QUIET_MISS: assert property (@(posedge clk) disable iff (!rstN)
    !hit |-> outcome == '0); // R1
  AST_EL0_UNDEF: assert property (@(posedge clk) disable iff (!rstN)
    (hit && curEl == 2'd0) |-> outcome.undef); // R2
  AST_EL1_EL2TRAP: assert property (@(posedge clk) disable iff (!rstN)
    (hit && curEl == 2'd1 && !(el3Present && !monTagAccess && sddUndefPrio) && el2Enabled && !hypTagAccess)
      |-> outcome.trapEl2); // R3
  AST_NO_EL2_TRAP: assert property (@(posedge clk) disable iff (!rstN)
    (curEl != 2'd1) |-> !outcome.trapEl2); // R4
  AST_EL3_OK: assert property (@(posedge clk) disable iff (!rstN)
    (hit && curEl == 2'd3) |-> outcome.ok); // R5
  AST_TRAP_CLASS: assert property (@(posedge clk) disable iff (!rstN)
    (outcome.trapEl2 || outcome.trapEl3) |-> syndromeClass == 6'h18); // R6
  AST_ONEHOT_HIT: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> $onehot(outcome)); // R12
  AST_WRITE_NEEDS_OK: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrEn |-> (outcome.ok && reqWrite)); // R12
endmodule

// File: rtl/tsr_datapath.sv
module tsr_datapath
  import tsr_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  tsrStrobes_t            strobes,
  input  logic                   wideSeedMode,
  input  logic [REG_W-1:0]       wdata,
  input  logic [TAG_W-1:0]       genTag,
  input  logic [WIDE_SEED_W-1:0] genSeed,
  output logic [REG_W-1:0]       readData
);
  logic [REG_W-1:0] regQ;
  logic [REG_W-1:0] liveMask;
  logic [REG_W-1:0] genImage;

  assign liveMask = fieldMask(wideSeedMode);
  assign genImage = ({{(REG_W-TAG_W){1'b0}}, genTag} |
                     ({{(REG_W-WIDE_SEED_W){1'b0}}, genSeed} << SEED_LSB)) & liveMask;

  always_ff @(posedge clk) begin
    if (!rstN)              regQ <= '0;
    else if (strobes.wrEn)  regQ <= wdata & liveMask;
    else if (strobes.genEn) regQ <= genImage;
  end

  assign readData = strobes.rdEn ? (regQ & liveMask) : '0;

  AST_NARROW_RESV_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !wideSeedMode |-> (readData[REG_W-1:SEED_LSB+NARROW_SEED_W] == '0 && readData[SEED_LSB-1:TAG_W] == '0)); // R7
  AST_TOP_BYTE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    regQ[REG_W-1:SEED_LSB+WIDE_SEED_W] == '0); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.wrEn || strobes.genEn) |=> $stable(regQ)); // R12
  AST_RDATA_GATED: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.rdEn |-> readData == '0); // R12
endmodule

// File: rtl/tag_seed_sysreg.sv
module tag_seed_sysreg
  import tsr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic [1:0]  reqOp0,
  input  logic [2:0]  reqOp1,
  input  logic [3:0]  reqCrn,
  input  logic [3:0]  reqCrm,
  input  logic [2:0]  reqOp2,
  input  logic [63:0] reqWdata,
  input  logic [1:0]  curEl,
  input  logic        el3Present,
  input  logic        el2Enabled,
  input  logic        sddUndefPrio,
  input  logic        sddUndef,
  input  logic        hypTagAccess,
  input  logic        monTagAccess,
  input  logic        wideSeedMode,
  input  logic        genValid,
  input  logic [3:0]  genTag,
  input  logic [47:0] genSeed,
  output logic [3:0]  outcome,
  output logic [63:0] rdata,
  output logic [5:0]  syndromeClass
);
  outcome_t    ctrlOutcome;
  tsrStrobes_t strobes;

  tsr_access_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqOp0(reqOp0), .reqOp1(reqOp1), .reqCrn(reqCrn), .reqCrm(reqCrm), .reqOp2(reqOp2),
    .curEl(curEl), .el3Present(el3Present), .el2Enabled(el2Enabled),
    .sddUndefPrio(sddUndefPrio), .sddUndef(sddUndef),
    .hypTagAccess(hypTagAccess), .monTagAccess(monTagAccess), .genValid(genValid),
    .outcome(ctrlOutcome), .syndromeClass(syndromeClass), .strobes(strobes)
  );

  tsr_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wideSeedMode(wideSeedMode),
    .wdata(reqWdata), .genTag(genTag), .genSeed(genSeed), .readData(rdata)
  );

  assign outcome = ctrlOutcome;
endmodule

// File: tb/tag_seed_sysreg_bench.sv
module tag_seed_sysreg_bench;
  logic clk = 1'b0;
  logic rstN;
  logic reqValid, reqWrite;
  logic [1:0] reqOp0;
  logic [2:0] reqOp1;
  logic [3:0] reqCrn, reqCrm;
  logic [2:0] reqOp2;
  logic [63:0] reqWdata;
  logic [1:0] curEl;
  logic el3Present, el2Enabled, sddUndefPrio, sddUndef, hypTagAccess, monTagAccess;
  logic wideSeedMode, genValid;
  logic [3:0] genTag;
  logic [47:0] genSeed;
  logic [3:0] outcome;
  logic [63:0] rdata;
  logic [5:0] syndromeClass;

  int total = 0;
  int bad = 0;
  logic [3:0] gotOut;
  logic [63:0] gotData;
  logic [5:0] gotClass;

  localparam logic [3:0] OK = 4'b0001, UND = 4'b0010, TR2 = 4'b0100, TR3 = 4'b1000;

  typedef struct packed {
    logic [1:0] el;
    logic e3p, e2en, prio, sddU, hAta, mAta;
    logic [3:0] expOut;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, UND}, // R2
    '{2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, UND}, // R3 step a
    '{2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, TR2}, // R3 step b
    '{2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, TR3}, // R3 step c trap
    '{2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, UND}, // R3 step c undef
    '{2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, OK},  // R3 step d
    '{2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, OK},  // R3 monitor absent
    '{2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, TR2}, // R3 hyp only
    '{2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, TR3}, // R4 no hyp step
    '{2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, UND}, // R4 priority undef
    '{2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, OK},  // R4
    '{2'd3, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, OK}   // R5
  };

  tag_seed_sysreg u_tag_seed_sysreg (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqOp0(reqOp0), .reqOp1(reqOp1), .reqCrn(reqCrn), .reqCrm(reqCrm), .reqOp2(reqOp2),
    .reqWdata(reqWdata), .curEl(curEl), .el3Present(el3Present), .el2Enabled(el2Enabled),
    .sddUndefPrio(sddUndefPrio), .sddUndef(sddUndef), .hypTagAccess(hypTagAccess),
    .monTagAccess(monTagAccess), .wideSeedMode(wideSeedMode), .genValid(genValid),
    .genTag(genTag), .genSeed(genSeed), .outcome(outcome), .rdata(rdata),
    .syndromeClass(syndromeClass)
  );

  always #2 clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic setCfg(input logic [1:0] el, input logic e3p, input logic e2en,
                        input logic prio, input logic sddU, input logic hAta, input logic mAta);
    curEl = el; el3Present = e3p; el2Enabled = e2en;
    sddUndefPrio = prio; sddUndef = sddU; hypTagAccess = hAta; monTagAccess = mAta;
  endtask

  // one access, with optional generator update in the same cycle
  task automatic access(input logic wr, input logic [63:0] d, input logic [2:0] op2,
                        input logic gen);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqWdata = d;
    reqOp0 = 2'b11; reqOp1 = 3'b000; reqCrn = 4'b0001; reqCrm = 4'b0000; reqOp2 = op2;
    genValid = gen;
    #1;
    gotOut = outcome; gotData = rdata; gotClass = syndromeClass;
    @(posedge clk);
    #1;
    reqValid = 1'b0; reqWrite = 1'b0; genValid = 1'b0;
  endtask

  task automatic genOnly();
    @(negedge clk);
    genValid = 1'b1;
    @(posedge clk);
    #1;
    genValid = 1'b0;
  endtask

  task automatic readAtTop(output logic [63:0] v);
    setCfg(2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    access(1'b0, 64'd0, 3'b101, 1'b0);
    v = gotData;
  endtask

  initial begin
    #200000;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] v;
    rstN = 1'b0; reqValid = 1'b0; reqWrite = 1'b0; reqWdata = '0;
    reqOp0 = '0; reqOp1 = '0; reqCrn = '0; reqCrm = '0; reqOp2 = '0;
    wideSeedMode = 1'b0; genValid = 1'b0; genTag = '0; genSeed = '0;
    setCfg(2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    readAtTop(v);
    check("R10 reset value", v, 64'd0);

    for (int i = 0; i < NVEC; i++) begin
      setCfg(VECS[i].el, VECS[i].e3p, VECS[i].e2en, VECS[i].prio,
             VECS[i].sddU, VECS[i].hAta, VECS[i].mAta);
      access(1'b0, 64'd0, 3'b101, 1'b0);
      check("R3/R12 outcome table", {60'd0, gotOut}, {60'd0, VECS[i].expOut});
      check("R6 syndrome class", {58'd0, gotClass},
            (VECS[i].expOut == TR2 || VECS[i].expOut == TR3) ? 64'h18 : 64'h0);
    end

    // R7 narrow write masking, R9 next-cycle visibility
    setCfg(2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    access(1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 3'b101, 1'b0);
    check("R5 write at top level ok", {60'd0, gotOut}, {60'd0, OK});
    check("R12 rdata zero on write", gotData, 64'd0);
    readAtTop(v);
    check("R7 R9 narrow layout read", v, 64'h0000_0000_00FF_FF0F);

    // R8 wide layout
    wideSeedMode = 1'b1;
    access(1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 3'b101, 1'b0);
    readAtTop(v);
    check("R8 wide layout read", v, 64'h00FF_FFFF_FFFF_FF0F);
    wideSeedMode = 1'b0;
    readAtTop(v);
    check("R7 narrow read of wide value", v, 64'h0000_0000_00FF_FF0F);

    // R1 wrong encoding: no outcome, no write
    access(1'b1, 64'h0, 3'b100, 1'b0);
    check("R1 miss outcome", {60'd0, gotOut}, 64'd0);
    readAtTop(v);
    check("R1 miss leaves value", v, 64'h0000_0000_00FF_FF0F);

    // R12 denied write leaves value
    setCfg(2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    access(1'b1, 64'h0, 3'b101, 1'b0);
    check("R12 denied write trap", {60'd0, gotOut}, {60'd0, TR3});
    readAtTop(v);
    check("R12 denied write no effect", v, 64'h0000_0000_00FF_FF0F);

    // R12 denied read returns zero data
    setCfg(2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    access(1'b0, 64'h0, 3'b101, 1'b0);
    check("R12 denied read data", gotData, 64'd0);

    // R11 generator update, narrow
    genTag = 4'h5; genSeed = 48'hABCD_1234_5678;
    genOnly();
    readAtTop(v);
    check("R11 narrow generator load", v, 64'h0000_0000_0056_7805);

    // R11 collision: software write wins
    access(1'b1, 64'h1111_2222, 3'b101, 1'b1);
    readAtTop(v);
    check("R11 software write wins", v, 64'h0000_0000_0011_2202);

    // R11 generator update, wide
    wideSeedMode = 1'b1;
    genTag = 4'hA;
    genOnly();
    readAtTop(v);
    check("R11 wide generator load", v, 64'h00AB_CD12_3456_780A);

    // R10 reset clears again
    @(negedge clk) rstN = 1'b0;
    @(posedge clk);
    #1 rstN = 1'b1;
    readAtTop(v);
    check("R10 reset clears", v, 64'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule